// File: doc/BRIEF.md
# Dual-Mode Serial Shifter

This block moves words over a single serial data pair in one of two framings. In asynchronous mode it acts as a UART-style channel: it hunts for a falling start edge, checks the line again half a bit later, samples each data bit at mid-bit from a 16x oversampling tick, and checks the stop bit. In synchronous mode the start and stop framing is switched off and the same logic runs as a clocked slave: a select input opens a frame, rising shift-clock edges capture data, falling edges advance the transmit bit, and releasing the select ends the frame.

Both modes share one receive shift register, one received-word holding register, one length register and one small register map. Software writes the word length. Reading that same address returns the receiver's live down-counter together with its two state bits, so an idle channel, a channel in the middle of a frame and a channel holding a finished word each read back as a distinct value. In synchronous mode a frame is kept only when the number of clock edges seen is a whole multiple of eight, so a single stray clock edge throws the frame away. A one-cycle transmit-done pulse lets a half-duplex line driver be released.

Top module: `sershift_top`

## Requirements
- R1: After reset the status word (address 2) reads 0, the counter readback (address 0) reads the idle code for the default length of 8 (0x0A in asynchronous mode), and in asynchronous mode `txd` is high whenever the transmitter is idle.
- R2: In asynchronous mode a frame of one low start bit, N data bits sent LSB first (N = length register, 16 ticks per bit) and a high stop bit places the data in bits N-1:0 of address 1 (upper bits zero) and sets status bit 0 (word valid); reading address 1 with `rd_en` clears that bit.
- R3: A low level on `rxd` that has ended before half a bit period (8 ticks) after its falling edge returns the receiver to the idle state without storing a word; while the check is pending the readback shows state 1.
- R4: The counter readback at address 0 is {state[1:0], count[5:0]} in bits 7:0, with state 0 = idle, 1 = start check, 2 = shifting, 3 = done. When idle the count equals N+2 in asynchronous mode and N in synchronous mode; it drops by one at the verified start bit and at each sampled bit (asynchronous) or at each rising clock edge (synchronous), and never by more than one per clock.
- R5: When a word is stored the readback shows state 3 with the count reloaded to its idle value; it returns to state 0 when address 1 is read.
- R6: A stop bit sampled low still stores the word and sets status bit 2 (framing error), which stays set until status is read with `rd_en`.
- R7: A word stored while status bit 0 is still set overwrites the held word and sets status bit 3 (overrun), which stays set until status is read with `rd_en`.
- R8: In synchronous mode (`sync_mode` high) a frame is the time `sel_n` is low; `rxd` is captured LSB first on rising `sclk`, and on release a frame with a non-zero edge count that is a multiple of 8 stores its first N bits exactly as in R2.
- R9: A synchronous frame whose edge count is not a multiple of 8 stores nothing: status bit 0 stays clear and the readback returns to the idle code.
- R10: In asynchronous mode a write to address 1 while the transmitter is idle sends a low start bit, N data bits LSB first and a high stop bit, 16 ticks each; status bit 1 (transmit busy) is high meanwhile, and `tx_done` pulses for one clock as busy drops.
- R11: In synchronous mode a write to address 1 puts data bit 0 on `txd`, each falling `sclk` while selected moves to the next bit, and releasing `sel_n` clears status bit 1 and pulses `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1 = clocked slave framing, 0 = start/stop framing |
| baud_tick | input | 1 | One-clock pulse at 16 times the bit rate |
| rxd | input | 1 | Serial data in |
| txd | output | 1 | Serial data out |
| sclk | input | 1 | External shift clock (synchronous mode) |
| sel_n | input | 1 | Active-low frame select (synchronous mode) |
| tx_done | output | 1 | One-clock pulse when a transmission ends |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (triggers read side effects) |
| addr | input | 2 | Register address: 0 length/counter, 1 data, 2 status |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data (combinational on addr) |

## Verification
A table of asynchronous frames with different lengths and bit patterns (alternating bits, a short 5-bit word whose unsent upper bits must read as zero, a full 16-bit word) separates correct bit ordering and length masking from a receiver that shifts the wrong way or ignores the length register. A start pulse of a quarter bit is aimed at the mid-bit recheck, and a frame with a low stop bit and two back-to-back frames with no read between them separate the two sticky error flags. Synchronous frames of 8, 9, 7 and 16 clock edges tell the multiple-of-eight commit apart from a plain edge-count or length match, and the readback is sampled mid-frame in both modes to show the live down-count. Transmit is watched bit by bit on `txd` in both framings.

// File: rtl/sershift_pkg.sv
`timescale 1ns/1ps
package sershift_pkg;

    // Receiver control states: all four codes of the two-bit field are used
    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_VERIFY = 2'd1,
        RX_SHIFT  = 2'd2,
        RX_DONE   = 2'd3
    } rx_state_e;

    // Register addresses
    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_DATA = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    // Status bit positions
    localparam int ST_VALID = 0;
    localparam int ST_BUSY  = 1;
    localparam int ST_FERR  = 2;
    localparam int ST_OVR   = 3;

endpackage

// File: rtl/sershift_sync.sv
`timescale 1ns/1ps
module sershift_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            logic [STAGES-1:0] chain_d;

            always_comb begin
                chain_d = {chain_q[STAGES-2:0], din[g]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
                else        chain_q <= chain_d;
            end

            assign dout[g] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sershift_rx.sv
`timescale 1ns/1ps
module sershift_rx import sershift_pkg::*; #(
    parameter int DW  = 16,
    parameter int LW  = 5,
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_mode,
    input  logic              tick,
    input  logic              rx_i,
    input  logic              sclk_i,
    input  logic              sel_i,
    input  logic [LW-1:0]     len,
    input  logic              clr_done,
    output logic              commit_o,
    output logic              ferr_o,
    output logic [DW-1:0]     word_o,
    output rx_state_e         state_o,
    output logic [LW:0]       cnt_o
);

    localparam int CW = LW + 1;
    localparam int TW = $clog2(OSR);
    localparam int IW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [TW-1:0] T_HALF = TW'(OSR / 2 - 1);
    localparam logic [TW-1:0] T_FULL = TW'(OSR - 1);

    typedef struct packed {
        rx_state_e     state;
        logic [CW-1:0] cnt;
        logic [TW-1:0] tcnt;
        logic [2:0]    edges;
        logic          any_edge;
        logic [DW-1:0] sh;
        logic          rx_prev;
        logic          sclk_prev;
    } rx_regs_t;

    rx_regs_t q, d;
    logic [CW-1:0] reload;
    logic          fall, rise;

    function automatic logic [DW-1:0] put_bit(logic [DW-1:0] v, int pos, logic b);
        logic [DW-1:0] r;
        r = v;
        if (pos >= 0 && pos < DW) r[pos[IW-1:0]] = b;
        return r;
    endfunction

    assign reload = sync_mode ? CW'(len) : CW'(len) + CW'(2);
    assign fall   = q.rx_prev & ~rx_i;
    assign rise   = ~q.sclk_prev & sclk_i;

    always_comb begin
        d           = q;
        commit_o    = 1'b0;
        ferr_o      = 1'b0;
        d.rx_prev   = rx_i;
        d.sclk_prev = sclk_i;

        case (q.state)
            RX_IDLE: begin
                d.cnt      = reload;
                d.tcnt     = '0;
                d.edges    = '0;
                d.any_edge = 1'b0;
                if (sync_mode) begin
                    if (sel_i) begin
                        d.state = RX_SHIFT;
                        d.sh    = '0;
                    end
                end else if (fall) begin
                    d.state = RX_VERIFY;
                    d.sh    = '0;
                end
            end

            RX_VERIFY: begin
                if (tick) begin
                    if (q.tcnt == T_HALF) begin
                        d.tcnt = '0;
                        if (!rx_i) begin
                            d.state = RX_SHIFT;
                            d.cnt   = q.cnt - CW'(1);
                        end else begin
                            d.state = RX_IDLE;
                        end
                    end else begin
                        d.tcnt = q.tcnt + TW'(1);
                    end
                end
            end

            RX_SHIFT: begin
                if (sync_mode) begin
                    if (rise) begin
                        d.edges    = q.edges + 3'd1;
                        d.any_edge = 1'b1;
                        if (q.cnt != '0) begin
                            d.sh  = put_bit(q.sh, int'(len) - int'(q.cnt), rx_i);
                            d.cnt = q.cnt - CW'(1);
                        end
                    end
                    if (!sel_i) begin
                        if (d.edges == 3'd0 && d.any_edge) begin
                            commit_o = 1'b1;
                            d.state  = RX_DONE;
                            d.cnt    = reload;
                        end else begin
                            d.state = RX_IDLE;
                        end
                    end
                end else if (tick) begin
                    if (q.tcnt == T_FULL) begin
                        d.tcnt = '0;
                        if (q.cnt > CW'(1)) begin
                            d.sh  = put_bit(q.sh, int'(len) + 1 - int'(q.cnt), rx_i);
                            d.cnt = q.cnt - CW'(1);
                        end else begin
                            ferr_o   = ~rx_i;
                            commit_o = 1'b1;
                            d.state  = RX_DONE;
                            d.cnt    = reload;
                        end
                    end else begin
                        d.tcnt = q.tcnt + TW'(1);
                    end
                end
            end

            default: begin
                d.cnt      = reload;
                d.tcnt     = '0;
                d.edges    = '0;
                d.any_edge = 1'b0;
                if (sync_mode && sel_i) begin
                    d.state = RX_SHIFT;
                    d.sh    = '0;
                end else if (!sync_mode && fall) begin
                    d.state = RX_VERIFY;
                    d.sh    = '0;
                end else if (clr_done) begin
                    d.state = RX_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.state     <= RX_IDLE;
            q.rx_prev   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign word_o  = d.sh;
    assign state_o = q.state;
    assign cnt_o   = q.cnt;

endmodule

// File: rtl/sershift_tx.sv
`timescale 1ns/1ps
module sershift_tx #(
    parameter int DW  = 16,
    parameter int LW  = 5,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_mode,
    input  logic          tick,
    input  logic          sclk_i,
    input  logic          sel_i,
    input  logic [LW-1:0] len,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    output logic          txd_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam int CW = LW + 1;
    localparam int TW = $clog2(OSR);
    localparam logic [TW-1:0] T_FULL = TW'(OSR - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic          txd;
        logic [DW-1:0] sh;
        logic [CW-1:0] bcnt;
        logic [TW-1:0] tcnt;
        logic          sclk_prev;
        logic          sel_prev;
    } tx_regs_t;

    tx_regs_t q, d;
    logic     sclk_fall, sel_rel;

    assign sclk_fall = q.sclk_prev & ~sclk_i;
    assign sel_rel   = q.sel_prev & ~sel_i;

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.sclk_prev = sclk_i;
        d.sel_prev  = sel_i;

        if (!q.busy) begin
            if (!sync_mode) d.txd = 1'b1;
            if (load_i) begin
                d.busy = 1'b1;
                d.sh   = data_i;
                d.bcnt = '0;
                d.tcnt = '0;
                d.txd  = sync_mode ? data_i[0] : 1'b0;
            end
        end else if (sync_mode) begin
            if (sel_i && sclk_fall) begin
                d.sh  = q.sh >> 1;
                d.txd = d.sh[0];
            end
            if (sel_rel) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end else if (tick) begin
            if (q.tcnt == T_FULL) begin
                d.tcnt = '0;
                d.bcnt = q.bcnt + CW'(1);
                if (d.bcnt <= CW'(len)) begin
                    d.txd = q.sh[0];
                    d.sh  = q.sh >> 1;
                end else if (d.bcnt == CW'(len) + CW'(1)) begin
                    d.txd = 1'b1;
                end else begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end
            end else begin
                d.tcnt = q.tcnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd_o  = q.txd;
    assign busy_o = q.busy;
    assign done_o = q.done;

endmodule

// File: rtl/sershift_top.sv
`timescale 1ns/1ps
module sershift_top import sershift_pkg::*; #(
    parameter int DW      = 16,
    parameter int LW      = 5,
    parameter int OSR     = 16,
    parameter int LEN_RST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_mode,
    input  logic          baud_tick,
    input  logic          rxd,
    output logic          txd,
    input  logic          sclk,
    input  logic          sel_n,
    output logic          tx_done,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int CW = LW + 1;

    typedef struct packed {
        logic [LW-1:0] len;
        logic [DW-1:0] data;
        logic          valid;
        logic          ferr;
        logic          ovr;
    } top_regs_t;

    top_regs_t q, d;

    logic [2:0]    sync_out;
    logic          rx_s, sclk_s, sel_s;
    logic          commit, ferr_set, tx_busy;
    logic [DW-1:0] rx_word;
    rx_state_e     rx_state;
    logic [CW-1:0] rx_cnt;
    logic          rd_data_hit, rd_stat_hit, tx_load;
    logic          st_valid, st_ovr;

    sershift_sync #(.W(3), .STAGES(2), .RST_VAL(3'b101)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sel_n, sclk, rxd}),
        .dout  (sync_out)
    );

    assign rx_s   = sync_out[0];
    assign sclk_s = sync_out[1];
    assign sel_s  = ~sync_out[2];

    assign rd_data_hit = rd_en && (addr == ADDR_DATA);
    assign rd_stat_hit = rd_en && (addr == ADDR_STAT);
    assign tx_load     = wr_en && (addr == ADDR_DATA);

    sershift_rx #(.DW(DW), .LW(LW), .OSR(OSR)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .tick      (baud_tick),
        .rx_i      (rx_s),
        .sclk_i    (sclk_s),
        .sel_i     (sel_s),
        .len       (q.len),
        .clr_done  (rd_data_hit),
        .commit_o  (commit),
        .ferr_o    (ferr_set),
        .word_o    (rx_word),
        .state_o   (rx_state),
        .cnt_o     (rx_cnt)
    );

    sershift_tx #(.DW(DW), .LW(LW), .OSR(OSR)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (sync_mode),
        .tick      (baud_tick),
        .sclk_i    (sclk_s),
        .sel_i     (sel_s),
        .len       (q.len),
        .load_i    (tx_load),
        .data_i    (wdata),
        .txd_o     (txd),
        .busy_o    (tx_busy),
        .done_o    (tx_done)
    );

    always_comb begin
        d = q;
        if (wr_en && addr == ADDR_CNT) d.len = wdata[LW-1:0];
        if (rd_data_hit) d.valid = 1'b0;
        if (rd_stat_hit) begin
            d.ferr = 1'b0;
            d.ovr  = 1'b0;
        end
        if (commit) begin
            d.data  = rx_word;
            d.valid = 1'b1;
            if (q.valid && !rd_data_hit) d.ovr = 1'b1;
        end
        if (ferr_set) d.ferr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.len <= LW'(LEN_RST);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CNT:  rdata = DW'({rx_state, rx_cnt});
            ADDR_DATA: rdata = q.data;
            ADDR_STAT: begin
                rdata[ST_VALID] = q.valid;
                rdata[ST_BUSY]  = tx_busy;
                rdata[ST_FERR]  = q.ferr;
                rdata[ST_OVR]   = q.ovr;
            end
            default:   rdata = '0;
        endcase
    end

    assign st_valid = q.valid;
    assign st_ovr   = q.ovr;

endmodule

// File: rtl/sershift_chk.sv
`timescale 1ns/1ps
module sershift_chk #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_mode,
    input logic [1:0]    state,
    input logic [CW-1:0] cnt,
    input logic          rx_s,
    input logic          rx_valid,
    input logic          ovr,
    input logic          tx_busy,
    input logic          tx_done,
    input logic          txd
);

    // R3
    verify_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && $past(state) == 2'd1) |-> !$past(rx_s));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2 && $past(state) == 2'd2) |->
            (cnt == $past(cnt) || cnt == $past(cnt) - CW'(1)));

    // R5
    done_holds_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd3) |-> rx_valid);

    // R7
    ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(rx_valid));

    // R10
    tx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!tx_busy && $past(tx_busy)));

    // R1
    txd_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && $past(!sync_mode) && !tx_busy && $past(!tx_busy)) |-> txd);

endmodule

bind sershift_top sershift_chk #(.CW(LW + 1)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_mode (sync_mode),
    .state     (rx_state),
    .cnt       (rx_cnt),
    .rx_s      (rx_s),
    .rx_valid  (st_valid),
    .ovr       (st_ovr),
    .tx_busy   (tx_busy),
    .tx_done   (tx_done),
    .txd       (txd)
);

// File: tb/sershift_top_tb.sv
`timescale 1ns/1ps
module sershift_top_tb;

    logic        clk = 1'b0;
    logic        rst_n, sync_mode, baud_tick, rxd, sclk, sel_n, wr_en, rd_en;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        txd, tx_done;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sershift_top u_dut (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .baud_tick(baud_tick),
        .rxd(rxd), .txd(txd), .sclk(sclk), .sel_n(sel_n), .tx_done(tx_done),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    typedef struct packed {
        logic [4:0]  len;
        logic [15:0] word;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{5'd8,  16'h00A5, 16'h00A5},
        '{5'd8,  16'h005A, 16'h005A},
        '{5'd5,  16'hFFF3, 16'h0013},
        '{5'd16, 16'hBEEF, 16'hBEEF}
    };

    initial begin
        baud_tick = 1'b0;
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        addr  = a;
        rd_en = 1'b0;
        #1 v  = rdata;
    endtask

    task automatic rdclr(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        #1 v  = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] dat);
        @(negedge clk);
        addr  = a;
        wdata = dat;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_async(input logic [15:0] w, input int n, input logic stopb);
        rxd = 1'b0;
        hold(64);
        for (int i = 0; i < n; i++) begin
            rxd = w[i];
            hold(64);
        end
        rxd = stopb;
        hold(64);
        rxd = 1'b1;
        hold(8);
    endtask

    task automatic spi_frame(input logic [15:0] w, input int n, input int peek_at,
                             input logic [15:0] exp_mid);
        logic [15:0] v;
        sel_n = 1'b0;
        hold(6);
        for (int i = 0; i < n; i++) begin
            if (i == peek_at) begin
                peek(2'd0, v);
                chk("R4 sync mid-frame readback", v, exp_mid);
            end
            rxd = (i < 16) ? w[i] : 1'b0;
            hold(6);
            sclk = 1'b1;
            hold(6);
            sclk = 1'b0;
        end
        hold(6);
        sel_n = 1'b1;
        hold(8);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  bits;
        int          pulses;

        rst_n = 1'b0; sync_mode = 1'b0; rxd = 1'b1; sclk = 1'b0; sel_n = 1'b1;
        wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = '0;
        hold(5);
        rst_n = 1'b1;
        hold(5);

        // R1 reset state
        peek(2'd0, v); chk("R1 reset readback", v, 16'h000A);
        peek(2'd2, v); chk("R1 reset status", v, 16'h0000);
        chk("R1 reset txd", {15'd0, txd}, 16'h0001);

        // R2 R5 table of asynchronous frames
        foreach (VECS[k]) begin
            wr(2'd0, {11'd0, VECS[k].len});
            send_async(VECS[k].word, int'(VECS[k].len), 1'b1);
            peek(2'd0, v); chk("R5 done code", v, {8'd0, 2'b11, 6'(VECS[k].len + 2)});
            rdclr(2'd2, v); chk("R2 status valid", v, 16'h0001);
            rdclr(2'd1, v); chk("R2 received word", v, VECS[k].exp);
            peek(2'd0, v); chk("R5 idle after read", v, {8'd0, 2'b00, 6'(VECS[k].len + 2)});
            peek(2'd2, v); chk("R2 valid cleared", v, 16'h0000);
        end

        // R4 live counter during an asynchronous frame (length 8)
        wr(2'd0, 16'd8);
        bits = 8'hC6;
        rxd = 1'b0;
        hold(16);
        peek(2'd0, v); chk("R4 start-check readback", v, 16'h004A);
        hold(48);
        rxd = bits[0]; hold(64);
        rxd = bits[1]; hold(16);
        peek(2'd0, v); chk("R4 shifting readback", v, 16'h0088);
        hold(48);
        for (int i = 2; i < 8; i++) begin
            rxd = bits[i];
            hold(64);
        end
        rxd = 1'b1; hold(72);
        rdclr(2'd1, v); chk("R4 frame word", v, 16'h00C6);

        // R3 short start pulse rejected at mid-bit
        rxd = 1'b0;
        hold(12);
        peek(2'd0, v); chk("R3 start check entered", v, 16'h004A);
        hold(4);
        rxd = 1'b1;
        hold(48);
        peek(2'd0, v); chk("R3 back to idle", v, 16'h000A);
        peek(2'd2, v); chk("R3 nothing stored", v, 16'h0000);

        // R6 framing error
        send_async(16'h0033, 8, 1'b0);
        hold(64);
        rdclr(2'd2, v); chk("R6 framing error set", v, 16'h0005);
        peek(2'd2, v); chk("R6 framing error cleared", v, 16'h0001);
        rdclr(2'd1, v); chk("R6 word kept", v, 16'h0033);

        // R7 overrun
        send_async(16'h0011, 8, 1'b1);
        send_async(16'h0022, 8, 1'b1);
        peek(2'd1, v); chk("R7 newest word", v, 16'h0022);
        rdclr(2'd2, v); chk("R7 overrun set", v, 16'h0009);
        peek(2'd2, v); chk("R7 overrun cleared", v, 16'h0001);
        rdclr(2'd1, v);

        // R10 asynchronous transmit
        bits = 8'h96;
        wr(2'd1, 16'h0096);
        hold(32);
        chk("R10 start bit", {15'd0, txd}, 16'h0000);
        peek(2'd2, v); chk("R10 busy", v, 16'h0002);
        for (int i = 0; i < 8; i++) begin
            hold(64);
            chk("R10 data bit", {15'd0, txd}, {15'd0, bits[i]});
        end
        hold(64);
        chk("R10 stop bit", {15'd0, txd}, 16'h0001);
        pulses = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (tx_done) pulses++;
        end
        chk("R10 done pulse count", 16'(pulses), 16'd1);
        peek(2'd2, v); chk("R10 not busy", v, 16'h0000);

        // R8 synchronous receive, 8 edges
        sync_mode = 1'b1;
        hold(8);
        peek(2'd0, v); chk("R4 sync idle readback", v, 16'h0008);
        spi_frame(16'h00B4, 8, 3, 16'h0085);
        peek(2'd0, v); chk("R8 sync done code", v, 16'h00C8);
        rdclr(2'd1, v); chk("R8 sync word", v, 16'h00B4);

        // R9 stray edges rejected
        spi_frame(16'h01FF, 9, -1, 16'h0000);
        peek(2'd2, v); chk("R9 nine edges discarded", v, 16'h0000);
        peek(2'd0, v); chk("R9 idle after reject", v, 16'h0008);
        spi_frame(16'h007F, 7, -1, 16'h0000);
        peek(2'd2, v); chk("R9 seven edges discarded", v, 16'h0000);

        // R8 sixteen edges with length 16
        wr(2'd0, 16'd16);
        spi_frame(16'hBEEF, 16, -1, 16'h0000);
        peek(2'd0, v); chk("R8 sync done code 16", v, 16'h00D0);
        rdclr(2'd1, v); chk("R8 sync word 16", v, 16'hBEEF);

        // R11 synchronous transmit
        wr(2'd0, 16'd8);
        bits = 8'h3C;
        wr(2'd1, 16'h003C);
        hold(4);
        sel_n = 1'b0;
        hold(6);
        for (int i = 0; i < 8; i++) begin
            chk("R11 sync tx bit", {15'd0, txd}, {15'd0, bits[i]});
            sclk = 1'b1; hold(6);
            sclk = 1'b0; hold(6);
        end
        peek(2'd2, v); chk("R11 busy while selected", v & 16'h0002, 16'h0002);
        sel_n = 1'b1;
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tx_done) pulses++;
        end
        chk("R11 done pulse", 16'(pulses), 16'd1);
        peek(2'd2, v); chk("R11 busy cleared", v & 16'h0002, 16'h0000);
        rdclr(2'd1, v);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule